// File: doc/BRIEF.md
# Serial TDM Highway Slot Aligner

This block takes in one serial time-division-multiplexed highway and rebuilds its time-slot framing. It uses a master bit clock and a frame marker that the whole system shares. A frame starts when the marker reaches its active level. The active level and the master clock edge used to sample the marker are configuration inputs. The same settings are meant to apply to every highway instance.

The master clock runs at 8.192 MHz or 16.384 MHz, set by a static strap. The highway rate can be 2.048, 4.096, 8.192 or 16.384 Mbit/s. The block divides the master clock down to that rate and samples each serial bit in the middle of its period. It counts bits and slots from the frame start. At the end of each eight-bit slot it presents the byte and the slot number, with a one-cycle strobe.

The block also reports two kinds of framing error. An early frame marker sets a sticky flag and restarts the counts. A frame that ends with no marker sets a different sticky flag, and the counts wrap to slot 0. A strap and rate pair that cannot work keeps the block idle and drives a configuration error output.

Top module: `tdm_frame_aligner`

## Requirements
- R1: `mclk_fast` low means an 8.192 MHz master clock and high means 16.384 MHz. `rate_sel` values 0, 1, 2 and 3 select 2.048, 4.096, 8.192 and 16.384 Mbit/s. One bit lasts (master clock / rate) clock cycles, which is 1, 2, 4 or 8 cycles.
- R2: Let the rising master clock edge that first captures the marker as active be edge k. Edge k+1 begins bit 0 of slot 0. Bit j of the frame (counting from 0) occupies the clock cycles that end at edges k+2+j·N through k+1+(j+1)·N, where N is the bit length in cycles.
- R3: When `fsync_high` is 1 the marker is active while high. When it is 0 the marker is active while low.
- R4: When `fsync_on_fall` is 1 the marker is sampled on the falling master clock edge that comes before edge k. A pulse seen only at that falling edge then starts a frame. When it is 0 only rising edges sample the marker, and such a pulse is ignored.
- R5: Each bit is sampled at clock cycle N/2 (rounded down) of its period. Bits fill the byte most significant bit first. The rising edge that ends a slot's eighth bit puts the byte on `rx_byte` and raises `rx_valid` for exactly one cycle.
- R6: `rx_slot` gives the slot index of the byte, counted from 0. A frame has 32, 64, 128 or 256 slots for `rate_sel` 0, 1, 2 or 3.
- R7: A marker that arrives before the frame's last slot ends restarts counting at slot 0, bit 0. It also sets `misalign`, which stays set until reset.
- R8: If the last slot ends and no marker has arrived, the counts wrap to slot 0 and `sync_missing` is set. `sync_missing` stays set until reset. A marker that arrives exactly at the frame end sets neither flag.
- R9: With `mclk_fast`=0 and `rate_sel`=3, `cfg_err` is 1 and no byte is delivered.
- R10: Synchronous reset clears all counts, flags and outputs. After reset no byte is delivered until a frame marker is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync_in | input | 1 | Shared frame marker |
| fsync_high | input | 1 | 1: marker active high, 0: active low |
| fsync_on_fall | input | 1 | 1: sample marker on falling edge |
| mclk_fast | input | 1 | Strap: 0 = 8.192 MHz, 1 = 16.384 MHz |
| rate_sel | input | 2 | Highway rate code 0..3 |
| rx_serial | input | 1 | Serial highway data |
| rx_byte | output | 8 | Assembled slot byte |
| rx_slot | output | 8 | Slot index of `rx_byte` |
| rx_valid | output | 1 | One-cycle strobe for a completed slot |
| misalign | output | 1 | Sticky early-marker flag |
| sync_missing | output | 1 | Sticky missing-marker flag |
| cfg_err | output | 1 | Unusable strap/rate pair |

## Verification
The assertions check, on every cycle, properties that hold at all times. The detected frame event and the byte strobe last exactly one cycle. A detected marker moves the counters to slot 0. The slot index stays inside the frame. Both error flags stay set once set. A bad configuration keeps the block idle and silent. Other behaviour can only be shown by the bench's scenarios. These are the exact bit windows for every rate and strap pair, mid-bit sampling with a corrupted first cycle in each bit, MSB-first byte order, polarity, and the narrow marker pulse that only the falling-edge mode catches. They also include the restart after an early marker and the wrap when no marker arrives.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;

  typedef enum logic [1:0] {
    RATE_2M  = 2'd0,
    RATE_4M  = 2'd1,
    RATE_8M  = 2'd2,
    RATE_16M = 2'd3
  } hw_rate_e;

  localparam int LOG2_W = 3;

  // log2 of master clocks per data bit
  function automatic logic [LOG2_W-1:0] bit_div_log2(input logic fast, input hw_rate_e r);
    int v;
    v = 2 + int'(fast) - int'(r);
    return (v < 0) ? '0 : LOG2_W'(v);
  endfunction

  function automatic logic rate_cfg_ok(input logic fast, input hw_rate_e r);
    return !(!fast && (r == RATE_16M));
  endfunction

endpackage

// File: rtl/tdm_sync_detect.sv
module tdm_sync_detect (
  input  logic clk,
  input  logic rst,
  input  logic fs_raw,
  input  logic pol_high,
  input  logic use_fall,
  output logic sync_evt
);
  logic fs_fall_q;
  logic fs_sel;
  logic act_q1, act_q2;

  // falling-edge capture of the marker
  always_ff @(negedge clk) begin
    fs_fall_q <= fs_raw;
  end

  always_comb fs_sel = use_fall ? fs_fall_q : fs_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q1 <= 1'b0;
      act_q2 <= 1'b0;
    end else begin
      act_q1 <= pol_high ? fs_sel : ~fs_sel;
      act_q2 <= act_q1;
    end
  end

  always_comb sync_evt = act_q1 & ~act_q2;

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sync_evt |=> !sync_evt); // R2

endmodule

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer
  import tdm_align_pkg::*;
#(
  parameter int BITS_PER_SLOT = 8,
  parameter int BASE_SLOTS    = 32,
  parameter int SLOT_IDX_W    = 8,
  parameter int DIV_W         = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sync_evt,
  input  logic                  cfg_ok,
  input  logic [LOG2_W-1:0]     div_log2,
  input  hw_rate_e              rate,
  output logic                  sample_stb,
  output logic                  slot_done,
  output logic [SLOT_IDX_W-1:0] slot_idx,
  output logic                  locked,
  output logic                  misalign,
  output logic                  sync_missing
);
  localparam int BIT_W = $clog2(BITS_PER_SLOT);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_SLOT - 1);

  logic [DIV_W-1:0]      div_cnt, div_last, div_mid;
  logic [BIT_W-1:0]      bit_cnt;
  logic [SLOT_IDX_W-1:0] slot_last;
  logic                  at_bit_end, at_slot_end, at_frame_end;

  always_comb begin
    div_last     = DIV_W'((32'd1 << div_log2) - 32'd1);
    div_mid      = DIV_W'((32'd1 << div_log2) >> 1);
    slot_last    = SLOT_IDX_W'((BASE_SLOTS << int'(rate)) - 1);
    at_bit_end   = (div_cnt == div_last);
    at_slot_end  = at_bit_end && (bit_cnt == BIT_LAST);
    at_frame_end = at_slot_end && (slot_idx == slot_last);
    sample_stb   = locked && (div_cnt == div_mid);
    slot_done    = locked && at_slot_end;
  end

  always_ff @(posedge clk) begin
    if (rst || !cfg_ok) begin
      div_cnt      <= '0;
      bit_cnt      <= '0;
      slot_idx     <= '0;
      locked       <= 1'b0;
      misalign     <= 1'b0;
      sync_missing <= 1'b0;
    end else if (sync_evt) begin
      div_cnt  <= '0;
      bit_cnt  <= '0;
      slot_idx <= '0;
      locked   <= 1'b1;
      if (locked && !at_frame_end) misalign <= 1'b1;
    end else if (locked) begin
      if (at_bit_end) begin
        div_cnt <= '0;
        if (bit_cnt == BIT_LAST) begin
          bit_cnt <= '0;
          if (at_frame_end) begin
            slot_idx     <= '0;
            sync_missing <= 1'b1;
          end else begin
            slot_idx <= slot_idx + 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    locked |-> (slot_idx <= slot_last)); // R6
  AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (sync_evt && cfg_ok) |=> (locked && slot_idx == '0)); // R2
  AST_MISALIGN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (misalign && cfg_ok) |=> misalign); // R7
  AST_MISSING_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sync_missing && cfg_ok) |=> sync_missing); // R8
  AST_BAD_CFG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> !locked); // R9

endmodule

// File: rtl/tdm_byte_assembler.sv
module tdm_byte_assembler #(
  parameter int BYTE_W     = 8,
  parameter int SLOT_IDX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_bit,
  input  logic                  sample_stb,
  input  logic                  slot_done,
  input  logic [SLOT_IDX_W-1:0] slot_idx,
  output logic [BYTE_W-1:0]     byte_q,
  output logic [SLOT_IDX_W-1:0] slot_q,
  output logic                  valid_q
);
  logic [BYTE_W-1:0] shreg, shreg_next;

  always_comb shreg_next = sample_stb ? {shreg[BYTE_W-2:0], rx_bit} : shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      byte_q  <= '0;
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      shreg   <= shreg_next;
      valid_q <= slot_done;
      if (slot_done) begin
        byte_q <= shreg_next;
        slot_q <= slot_idx;
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R5

endmodule

// File: rtl/tdm_frame_aligner.sv
module tdm_frame_aligner
  import tdm_align_pkg::*;
#(
  parameter int SLOT_BITS  = 8,
  parameter int BASE_SLOTS = 32,
  parameter int SLOT_IDX_W = 8,
  parameter int DIV_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fsync_in,
  input  logic                  fsync_high,
  input  logic                  fsync_on_fall,
  input  logic                  mclk_fast,
  input  logic [1:0]            rate_sel,
  input  logic                  rx_serial,
  output logic [SLOT_BITS-1:0]  rx_byte,
  output logic [SLOT_IDX_W-1:0] rx_slot,
  output logic                  rx_valid,
  output logic                  misalign,
  output logic                  sync_missing,
  output logic                  cfg_err
);
  hw_rate_e              rate;
  logic                  cfg_ok;
  logic [LOG2_W-1:0]     div_log2;
  logic                  sync_evt, sample_stb, slot_done, locked;
  logic [SLOT_IDX_W-1:0] slot_idx;

  always_comb begin
    rate     = hw_rate_e'(rate_sel);
    cfg_ok   = rate_cfg_ok(mclk_fast, rate);
    div_log2 = bit_div_log2(mclk_fast, rate);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= !cfg_ok;
  end

  tdm_sync_detect u_sync (
    .clk      (clk),
    .rst      (rst),
    .fs_raw   (fsync_in),
    .pol_high (fsync_high),
    .use_fall (fsync_on_fall),
    .sync_evt (sync_evt)
  );

  tdm_bit_timer #(
    .BITS_PER_SLOT (SLOT_BITS),
    .BASE_SLOTS    (BASE_SLOTS),
    .SLOT_IDX_W    (SLOT_IDX_W),
    .DIV_W         (DIV_W)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .sync_evt     (sync_evt),
    .cfg_ok       (cfg_ok),
    .div_log2     (div_log2),
    .rate         (rate),
    .sample_stb   (sample_stb),
    .slot_done    (slot_done),
    .slot_idx     (slot_idx),
    .locked       (locked),
    .misalign     (misalign),
    .sync_missing (sync_missing)
  );

  tdm_byte_assembler #(
    .BYTE_W     (SLOT_BITS),
    .SLOT_IDX_W (SLOT_IDX_W)
  ) u_asm (
    .clk        (clk),
    .rst        (rst),
    .rx_bit     (rx_serial),
    .sample_stb (sample_stb),
    .slot_done  (slot_done),
    .slot_idx   (slot_idx),
    .byte_q     (rx_byte),
    .slot_q     (rx_slot),
    .valid_q    (rx_valid)
  );

  AST_QUIET_ON_CFG_ERR: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !rx_valid); // R9

endmodule

// File: tb/tdm_frame_aligner_bench.sv
`timescale 1ns/1ps
module tdm_frame_aligner_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync_in = 1'b0, fsync_high = 1'b1, fsync_on_fall = 1'b0;
  logic       mclk_fast = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic       rx_serial = 1'b0;
  logic [7:0] rx_byte, rx_slot;
  logic       rx_valid, misalign, sync_missing, cfg_err;

  always #2.5 clk = ~clk;

  tdm_frame_aligner u_tdm_frame_aligner (
    .clk(clk), .rst(rst), .fsync_in(fsync_in), .fsync_high(fsync_high),
    .fsync_on_fall(fsync_on_fall), .mclk_fast(mclk_fast), .rate_sel(rate_sel),
    .rx_serial(rx_serial), .rx_byte(rx_byte), .rx_slot(rx_slot), .rx_valid(rx_valid),
    .misalign(misalign), .sync_missing(sync_missing), .cfg_err(cfg_err)
  );

  typedef struct packed { logic [7:0] slot; logic [7:0] data; } exp_t;
  exp_t  exp_q[$];
  int    checks = 0, errors = 0, valid_seen = 0, nper = 8, nslots = 32;
  string cur_req = "R10";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int slot, input int seed);
    return 8'((slot * 29 + seed * 71 + 5) & 255);
  endfunction

  // Monitor / scoreboard
  always @(posedge clk) begin
    #4;
    if (!rst && rx_valid) begin
      valid_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, "unexpected rx_valid, slot", int'(rx_slot), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rx_slot == e.slot, "R6", "slot index", int'(rx_slot), int'(e.slot));
        check(rx_byte == e.data, "R5", "byte value", int'(rx_byte), int'(e.data));
      end
    end
  end

  task automatic set_cfg(input logic fast, input logic [1:0] r, input logic hi,
                         input logic fall);
    rst = 1'b1;
    mclk_fast = fast; rate_sel = r; fsync_high = hi; fsync_on_fall = fall;
    fsync_in = ~hi; rx_serial = 1'b0;
    nper = 1 << (int'(fast) + 2 - int'(r));
    nslots = 32 << r;
    exp_q.delete();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Ends 1 ns after the edge that begins slot 0 bit 0
  task automatic start_sync(input bit narrow);
    fsync_in = fsync_high;
    if (narrow) #3 fsync_in = ~fsync_high;
    @(posedge clk); #1 fsync_in = ~fsync_high;
    @(posedge clk); #1;
  endtask

  task automatic run_frame(input int ns, input bit sync_next, input int seed);
    int total;
    total = ns * 8 * nper;
    for (int c = 0; c < total; c++) begin
      int slot, b, d;
      logic [7:0] v;
      slot = c / (8 * nper);
      b = (c / nper) % 8;
      d = c % nper;
      v = pat(slot, seed);
      if (b == 0 && d == 0) exp_q.push_back({8'(slot), v});
      rx_serial = v[7-b];
      if (nper >= 2 && d == 0) rx_serial = ~v[7-b];
      if (sync_next && c == total - 2) fsync_in = fsync_high;
      if (sync_next && c == total - 1) fsync_in = ~fsync_high;
      @(posedge clk); #1;
    end
  endtask

  task automatic drain(input string req);
    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0, req, "bytes still expected", exp_q.size(), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "WATCHDOG", "run did not finish, cycles", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int vs;
    // A: 16.384 MHz clock, 2.048 Mbit/s (N=8, 32 slots)
    set_cfg(1'b1, 2'd0, 1'b1, 1'b0);
    #3;
    check(rx_valid == 0, "R10", "rx_valid after reset", rx_valid, 0);
    check(misalign == 0 && sync_missing == 0, "R10", "flags after reset",
          int'({misalign, sync_missing}), 0);
    check(cfg_err == 0, "R10", "cfg_err after reset", cfg_err, 0);
    vs = valid_seen;
    repeat (100) @(posedge clk);
    #1;
    check(valid_seen == vs, "R10", "bytes before first marker", valid_seen - vs, 0);
    cur_req = "R1";
    start_sync(1'b0);
    run_frame(32, 1'b1, 1);
    check(sync_missing == 0 && misalign == 0, "R8", "flags after on-time marker",
          int'({misalign, sync_missing}), 0);
    run_frame(32, 1'b0, 2);
    check(sync_missing == 1, "R8", "sync_missing after frame with no marker",
          sync_missing, 1);
    drain("R1");

    // B: N=1, 256 slots
    set_cfg(1'b1, 2'd3, 1'b1, 1'b0);
    cur_req = "R2";
    start_sync(1'b0);
    run_frame(256, 1'b1, 3);
    run_frame(256, 1'b1, 4);
    check(sync_missing == 0 && misalign == 0, "R6", "flags after 256-slot frames",
          int'({misalign, sync_missing}), 0);
    drain("R6");

    // C: 8.192 MHz, 4.096 Mbit/s, active-low marker, falling-edge sampling, narrow pulse
    set_cfg(1'b0, 2'd1, 1'b0, 1'b1);
    cur_req = "R4";
    start_sync(1'b1);
    run_frame(64, 1'b1, 5);
    check(misalign == 0, "R3", "misalign with active-low marker", misalign, 0);
    drain("R3");

    // D: N=1, 128 slots, wrap without marker
    set_cfg(1'b0, 2'd2, 1'b1, 1'b0);
    cur_req = "R8";
    start_sync(1'b0);
    run_frame(128, 1'b0, 6);
    run_frame(128, 1'b0, 7);
    check(sync_missing == 1, "R8", "sync_missing after wrap", sync_missing, 1);
    check(misalign == 0, "R8", "misalign after wrap", misalign, 0);
    drain("R8");

    // E: early marker after 10 slots
    set_cfg(1'b1, 2'd2, 1'b1, 1'b0);
    cur_req = "R7";
    start_sync(1'b0);
    run_frame(10, 1'b1, 8);
    check(misalign == 1, "R7", "misalign after early marker", misalign, 1);
    run_frame(128, 1'b1, 9);
    check(misalign == 1, "R7", "misalign stays set", misalign, 1);
    check(sync_missing == 0, "R7", "sync_missing after restart", sync_missing, 0);
    drain("R7");

    // F: narrow pulse ignored with rising-edge sampling
    set_cfg(1'b1, 2'd0, 1'b1, 1'b0);
    cur_req = "R4";
    vs = valid_seen;
    start_sync(1'b1);
    repeat (600) @(posedge clk);
    #1;
    check(valid_seen == vs, "R4", "bytes after narrow pulse, rising mode",
          valid_seen - vs, 0);

    // G: unusable strap/rate pair
    set_cfg(1'b0, 2'd3, 1'b1, 1'b0);
    cur_req = "R9";
    @(posedge clk); #1;
    check(cfg_err == 1, "R9", "cfg_err for 8.192 MHz with 16.384 Mbit/s", cfg_err, 1);
    vs = valid_seen;
    start_sync(1'b0);
    repeat (300) @(posedge clk);
    #1;
    check(valid_seen == vs, "R9", "bytes while configuration is bad", valid_seen - vs, 0);

    // H: reset in mid-frame
    set_cfg(1'b1, 2'd3, 1'b1, 1'b0);
    cur_req = "R10";
    start_sync(1'b0);
    run_frame(5, 1'b0, 10);
    drain("R10");
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    vs = valid_seen;
    repeat (100) @(posedge clk);
    #1;
    check(valid_seen == vs, "R10", "bytes after mid-frame reset", valid_seen - vs, 0);
    check(rx_valid == 0 && rx_byte == 0, "R10", "outputs after mid-frame reset",
          int'(rx_byte), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule